// File: doc/BRIEF.md
# Prescaled 16-bit timer/counter

The block is a 16-bit up-counter that sits on an 8-bit register bus. It counts one of two sources. The first is an instruction-rate enable pulse from the system, which makes it a timer. The second is the rising edges of an external clock input, which makes it an event counter. A power-of-two prescaler of 1, 2, 4 or 8 sits in front of the counter. When the count wraps from 0xFFFF to 0x0000 it raises a sticky interrupt flag. A one-cycle trigger pulse from a neighbouring block clears the count.

The external input is treated as a digital signal and is sampled by the system clock. It passes through a two-flop synchroniser and a rising-edge detector. In synchronised mode the prescaled edge then goes through one more alignment flop before it reaches the counter. In unsynchronised mode that flop is bypassed, so the count moves one cycle earlier.

Software reaches the 16-bit count one byte at a time. In wide access mode a shadow register holds the high byte, so that a 16-bit value is read and written as one consistent value. Reading the low byte freezes the high byte for a later read. A write to the high byte is held until the low byte is written, and then both bytes load together.

Top module: `pre_timer16`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. The control register at address 2 reads back what was written into its bits [5:0], and those bits read 0 after reset.
- R2: With control bit 0 (run) set and control bit 1 (source) at 0, each cycle with `tick_i` high advances the count by one on that clock edge, when the prescaler is set to divide by 1.
- R3: Control bits [4:3] (prescale code p) divide the selected source by 2^p. The first increment comes on the 2^p-th source pulse, and the second on the 2^(p+1)-th.
- R4: While run is 0, source pulses leave the count unchanged.
- R5: With control bit 1 set, the count advances on rising edges of `ext_clk_i` and ignores `tick_i`. When control bit 2 (sync) is 0, the count changes on the third clock edge after the input rises. When sync is 1, it changes on the fourth.
- R6: A wrap from 0xFFFF to 0x0000 sets the flag. The flag is bit 0 at address 3 and also drives `irq_o`. Writing 1 to that bit leaves the flag set; only writing 0 clears it.
- R7: A pulse on `trig_clr_i` clears the count to 0, even in a cycle where an increment is also due.
- R8: A bus write that loads the count takes priority over a trigger in the same cycle. Any write to address 0 or 1 also restarts the prescaler.
- R9: With control bit 5 (wide) at 0, address 0 reads and writes count bits [7:0], and address 1 reads and writes count bits [15:8] directly.
- R10: With wide set, reading address 0 copies the live high byte into the shadow register, and address 1 then reads that shadow, even after the count moves on.
- R11: With wide set, a write to address 1 changes only the shadow. A later write to address 0 loads {shadow, written byte} into the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-rate count enable |
| ext_clk_i | input | 1 | External clock input, already digital |
| trig_clr_i | input | 1 | Trigger pulse that clears the count |
| addr_i | input | 2 | Register address: 0 low, 1 high, 2 control, 3 flag |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (a read of address 0 captures the shadow) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Overflow flag |

## Verification
Writes, internal ticks and trigger pulses take effect on the clock edge on which they are sampled, so the bench drives inputs on the falling edge and reads one half-cycle after the rising edge that follows. Read data is combinational from the address, so each read is sampled 1 ns after the address is driven. An external edge needs three clock edges in unsynchronised mode and four in synchronised mode. The bench counts those edges one by one and checks the count after the third edge and again after the fourth, which tells the two paths apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int PS_W   = 2;

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef struct packed {
    logic            wide;
    logic [PS_W-1:0] ps;
    logic            sync;
    logic            ext;
    logic            run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            pulse_i,
  output logic            pulse_o
);
  localparam int CW = (1 << PS_W) - 1;

  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] mask;

  assign mask    = ~({CW{1'b1}} << ps_i);
  assign pulse_o = pulse_i & (pcnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (clr_i)   pcnt_q <= '0;
    else if (pulse_o) pcnt_q <= '0;
    else if (pulse_i) pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [2*BYTE_W-1:0] load_data_i,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              ovf_clr_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic              ovf_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             load;
  logic             wrap;

  assign load = load_lo_i | load_hi_i;
  assign wrap = inc_i & ~load & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load) begin
      if (load_lo_i) cnt_q[BYTE_W-1:0]     <= load_data_i[BYTE_W-1:0];
      if (load_hi_i) cnt_q[CNT_W-1:BYTE_W] <= load_data_i[CNT_W-1:BYTE_W];
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/pre_timer16.sv
module pre_timer16
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic              trig_clr_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] hbuf_q;
  logic [CNT_W-1:0]  count_q;
  logic              ovf;
  logic              ext_rise;
  logic              src_pulse;
  logic              pre_pulse;
  logic              align_q;
  logic              inc;
  logic              wr_lo, wr_hi, wr_ctrl, wr_flag;
  logic              load_lo, load_hi;
  logic [CNT_W-1:0]  load_data;

  assign wr_lo   = wr_i && addr_i == A_LO;
  assign wr_hi   = wr_i && addr_i == A_HI;
  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_flag = wr_i && addr_i == A_FLAG;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (ext_clk_i),
    .rise_o (ext_rise)
  );

  assign src_pulse = ctrl_q.run & (ctrl_q.ext ? ext_rise : tick_i);

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_lo | wr_hi),
    .ps_i    (ctrl_q.ps),
    .pulse_i (src_pulse),
    .pulse_o (pre_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) align_q <= 1'b0;
    else         align_q <= pre_pulse;
  end

  assign inc = ctrl_q.run & ((ctrl_q.ext & ctrl_q.sync) ? align_q : pre_pulse);

  always_comb begin
    load_lo   = 1'b0;
    load_hi   = 1'b0;
    load_data = {wdata_i, wdata_i};
    if (ctrl_q.wide) begin
      if (wr_lo) begin
        load_lo   = 1'b1;
        load_hi   = 1'b1;
        load_data = {hbuf_q, wdata_i};
      end
    end else begin
      load_lo = wr_lo;
      load_hi = wr_hi;
    end
  end

  tmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_lo_i   (load_lo),
    .load_hi_i   (load_hi),
    .load_data_i (load_data),
    .clr_i       (trig_clr_i),
    .inc_i       (inc),
    .ovf_clr_i   (wr_flag & ~wdata_i[0]),
    .cnt_o       (count_q),
    .ovf_o       (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             hbuf_q <= '0;
    else if (ctrl_q.wide && wr_hi)           hbuf_q <= wdata_i;
    else if (ctrl_q.wide && rd_i && addr_i == A_LO) hbuf_q <= count_q[CNT_W-1:BYTE_W];
  end

  always_comb begin
    case (addr_i)
      A_LO:    rdata_o = count_q[BYTE_W-1:0];
      A_HI:    rdata_o = ctrl_q.wide ? hbuf_q : count_q[CNT_W-1:BYTE_W];
      A_CTRL:  rdata_o = BYTE_W'(ctrl_q);
      default: rdata_o = BYTE_W'(ovf);
    endcase
  end

  assign irq_o = ovf;
endmodule

// File: rtl/pre_timer16_chk.sv
module pre_timer16_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        trig_clr_i,
  input logic [1:0]  addr_i,
  input logic        wr_i,
  input logic [7:0]  wdata_i,
  input logic        irq_o,
  input logic [15:0] count_i,
  input logic [7:0]  hbuf_i,
  input logic        wide_i,
  input logic        run_i
);
  logic cnt_wr;
  assign cnt_wr = wr_i && (addr_i == 2'd0 || (addr_i == 2'd1 && !wide_i));

  // R7
  a_r7_trig_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_clr_i && !cnt_wr |=> count_i == 16'd0);

  // R6
  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(wr_i && addr_i == 2'd3 && !wdata_i[0]) |=> irq_o);

  // R4
  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !trig_clr_i && !cnt_wr |=> $stable(count_i));

  // R2
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_clr_i && !cnt_wr |=>
      (count_i == $past(count_i)) || (count_i == 16'($past(count_i) + 16'd1)));

  // R11
  a_r11_hi_to_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i && wr_i && addr_i == 2'd1 |=> hbuf_i == $past(wdata_i));

  // R11
  a_r11_lo_loads_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i && wr_i && addr_i == 2'd0 |=> count_i == {$past(hbuf_i), $past(wdata_i)});
endmodule

bind pre_timer16 pre_timer16_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_clr_i (trig_clr_i),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .count_i    (count_q),
  .hbuf_i     (hbuf_q),
  .wide_i     (ctrl_q.wide),
  .run_i      (ctrl_q.run)
);

// File: tb/pre_timer16_tb.sv
module pre_timer16_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       trig_clr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  pre_timer16 u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic set_count(input logic [7:0] hi, input logic [7:0] lo);
    bus_wr(2'd1, hi);
    bus_wr(2'd0, lo);
  endtask

  task automatic t_reset;
    rd_chk("R1 low", 2'd0, 8'h00);
    rd_chk("R1 high", 2'd1, 8'h00);
    rd_chk("R1 ctrl", 2'd2, 8'h00);
    rd_chk("R1 flag", 2'd3, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    bus_wr(2'd2, 8'h3E);
    rd_chk("R1 ctrl readback", 2'd2, 8'h3E);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_internal;
    bus_wr(2'd2, 8'h01);
    set_count(8'h00, 8'h00);
    ticks(5);
    rd_chk("R2 five ticks", 2'd0, 8'h05);
  endtask

  task automatic t_prescale;
    for (int p = 1; p < 4; p++) begin
      bus_wr(2'd2, 8'h01 | 8'(p << 3));
      set_count(8'h00, 8'h00);
      ticks((1 << p) - 1);
      rd_chk("R3 before first", 2'd0, 8'h00);
      ticks(1);
      rd_chk("R3 first", 2'd0, 8'h01);
      ticks(1 << p);
      rd_chk("R3 second", 2'd0, 8'h02);
    end
  endtask

  task automatic t_hold;
    bus_wr(2'd2, 8'h00);
    set_count(8'h00, 8'h07);
    ticks(4);
    rd_chk("R4 held", 2'd0, 8'h07);
  endtask

  task automatic t_pre_restart;
    bus_wr(2'd2, 8'h11);
    set_count(8'h00, 8'h00);
    ticks(3);
    bus_wr(2'd0, 8'h10);
    ticks(3);
    rd_chk("R8 prescaler restarted", 2'd0, 8'h10);
    ticks(1);
    rd_chk("R8 after restart", 2'd0, 8'h11);
  endtask

  task automatic ext_pulse(input logic sync, input string req);
    bus_wr(2'd2, sync ? 8'h07 : 8'h03);
    set_count(8'h00, 8'h00);
    ticks(3);
    rd_chk({req, " tick ignored"}, 2'd0, 8'h00);
    @(negedge clk_i);
    addr_i = 2'd0; ext_clk_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " third edge"}, rdata_o, sync ? 8'h00 : 8'h01);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({req, " fourth edge"}, rdata_o, 8'h01);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_ovf;
    bus_wr(2'd2, 8'h01);
    set_count(8'hFF, 8'hFF);
    ticks(1);
    rd_chk("R6 wrapped low", 2'd0, 8'h00);
    rd_chk("R6 wrapped high", 2'd1, 8'h00);
    rd_chk("R6 flag set", 2'd3, 8'h01);
    chk("R6 irq set", {7'd0, irq_o}, 8'h01);
    bus_wr(2'd3, 8'h01);
    rd_chk("R6 write one keeps", 2'd3, 8'h01);
    bus_wr(2'd3, 8'h00);
    rd_chk("R6 write zero clears", 2'd3, 8'h00);
    chk("R6 irq cleared", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_trig;
    bus_wr(2'd2, 8'h01);
    set_count(8'h00, 8'h55);
    @(negedge clk_i); trig_clr_i = 1'b1;
    @(negedge clk_i); trig_clr_i = 1'b0;
    rd_chk("R7 cleared", 2'd0, 8'h00);
    set_count(8'h00, 8'h55);
    @(negedge clk_i); trig_clr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); trig_clr_i = 1'b0; tick_i = 1'b0;
    rd_chk("R7 clear beats increment", 2'd0, 8'h00);
    @(negedge clk_i);
    addr_i = 2'd0; wdata_i = 8'h66; wr_i = 1'b1; trig_clr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; trig_clr_i = 1'b0;
    rd_chk("R8 write beats trigger", 2'd0, 8'h66);
  endtask

  task automatic t_direct;
    bus_wr(2'd2, 8'h00);
    set_count(8'h00, 8'h00);
    bus_wr(2'd1, 8'h5A);
    rd_chk("R9 high direct", 2'd1, 8'h5A);
    rd_chk("R9 low untouched", 2'd0, 8'h00);
    bus_wr(2'd0, 8'hC3);
    rd_chk("R9 low direct", 2'd0, 8'hC3);
    rd_chk("R9 high kept", 2'd1, 8'h5A);
  endtask

  task automatic t_wide;
    bus_wr(2'd2, 8'h01);
    set_count(8'h00, 8'h00);
    bus_wr(2'd2, 8'h21);
    bus_wr(2'd1, 8'hAB);
    rd_chk("R11 low after hi write", 2'd0, 8'h00);
    rd_chk("R11 live high untouched", 2'd1, 8'h00);
    bus_wr(2'd1, 8'h12);
    bus_wr(2'd0, 8'h34);
    rd_chk("R11 low loaded", 2'd0, 8'h34);
    rd_chk("R11 high loaded", 2'd1, 8'h12);
    bus_wr(2'd1, 8'h12);
    bus_wr(2'd0, 8'hFF);
    rd_chk("R10 low read", 2'd0, 8'hFF);
    ticks(1);
    rd_chk("R10 high from shadow", 2'd1, 8'h12);
    rd_chk("R10 low after carry", 2'd0, 8'h00);
    rd_chk("R10 fresh high", 2'd1, 8'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_internal();
    t_prescale();
    t_hold();
    t_pre_restart();
    ext_pulse(1'b0, "R5 unsync");
    ext_pulse(1'b1, "R5 sync");
    t_ovf();
    t_trig();
    t_direct();
    t_wide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule